// File: doc/BRIEF.md
# Capture / Auto-Reload Timer

This block is a 16-bit up-counter that advances on an internal tick enable or on falling edges of an external count pin. It has an 8-bit control word and a 16-bit companion register. A falling edge on an external trigger pin can do one of two things, depending on the mode. It can snapshot the running count into the companion register, or it can reload the count from that register. In reload mode, a count overflow also reloads the counter.

Setting either serial-clock select bit turns the block into a baud-rate source. In that role the counter always reloads on overflow. Each overflow is sent as a one-cycle pulse to the receive or transmit clock output, or to both. The overflow flag stays clear, and the trigger pin cannot capture or reload the count.

Two sticky flags record overflow and trigger events. Their OR, gated by an enable input, forms the interrupt request. All state is reached through a byte-wide register port.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the control word, count and companion register read 0, and irq, rx_clk_pulse and tx_clk_pulse are 0.
- R2: Register port. Address 0 is the control word. Address 1 is the count low byte and address 2 the count high byte. Address 3 is the companion low byte and address 4 the companion high byte. A write takes effect at the next clock edge, and reg_rdata shows the addressed register combinationally. A bus write to a count byte overrides hardware updates of that byte. A capture overrides a bus write to the companion register.
- R3: The control bits are: bit 2 run, bit 1 source select, bit 0 capture mode. With run=1 and source select 0, the count adds 1 on each clock edge where tick_en=1. With run=0 the count holds.
- R4: With source select 1, the count adds 1 per falling edge of count_pin. Each pin passes through two synchronizer flops, and an edge is a 1 sample followed by a 0 sample. The count changes on the third rising edge after the pin falls.
- R5: An increment from 0xFFFF is an overflow. It sets control bit 7 (overflow flag) unless bit 5 or bit 4 is 1. The flag is cleared only by writing 0 to it, and a hardware set in the same cycle as that write wins.
- R6: With bit 3 (trigger enable)=1, capture mode=1 and bits 5 and 4 both 0, a trigger_pin falling edge copies the current count into the companion register. Counting carries on unchanged.
- R7: With capture mode=0, every overflow loads the count from the companion register. A trigger falling edge with trigger enable=1 and bits 5 and 4 both 0 does the same.
- R8: Bit 5 (receive clock select) or bit 4 (transmit clock select) set means baud mode. In baud mode, overflow always reloads and the trigger never captures or reloads. Each overflow gives a one-cycle pulse on rx_clk_pulse and/or tx_clk_pulse, one cycle later, for each select bit that is set.
- R9: A trigger falling edge with trigger enable=1 sets control bit 6 (event flag) in every mode. The flag is cleared only by a write, and a hardware set wins over a write in the same cycle.
- R10: With trigger enable=0, trigger_pin edges change neither the flags, the count nor the companion register.
- R11: irq equals (bit 7 OR bit 6) AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| tick_en | input | 1 | Internal count tick |
| count_pin | input | 1 | External count input |
| trigger_pin | input | 1 | External capture/reload trigger |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| rx_clk_pulse | output | 1 | Overflow pulse for the receive clock |
| tx_clk_pulse | output | 1 | Overflow pulse for the transmit clock |

## Verification
The risky collisions are these: an overflow landing in the same cycle as a trigger edge, and a hardware flag set or capture landing on the same edge as a bus write to the same register. Counts are preset near 0xFFFF and both pins toggle at random while writes arrive at random. This makes overflows, trigger edges and writes coincide often. A cycle-accurate bench model, built from the requirements and following the stated priorities, judges every register, the interrupt and the pulse outputs on each cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int B_OVF  = 7;
    localparam int B_EVT  = 6;
    localparam int B_RXS  = 5;
    localparam int B_TXS  = 4;
    localparam int B_TEN  = 3;
    localparam int B_RUN  = 2;
    localparam int B_SRC  = 1;
    localparam int B_CAP  = 0;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2,
    localparam int L = STAGES + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [L-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[L-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[L-1] & ~sh_q[L-2];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NB = CNT_W / BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_sel,
    input  logic             cap_mode,
    input  logic             rx_sel,
    input  logic             tx_sel,
    input  logic             trig_en,
    input  logic             tick,
    input  logic             cnt_fall,
    input  logic             trig_fall,
    input  logic [NB-1:0]    cnt_wr,
    input  logic [NB-1:0]    rl_wr,
    input  byte_t            wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             ovf_evt,
    output logic             trig_evt,
    output logic             rx_pulse,
    output logic             tx_pulse
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             rx;
        logic             tx;
    } core_st_t;

    core_st_t st_d, st_q;
    logic baud, inc, rl_evt, cap_evt;

    always_comb begin
        baud     = rx_sel | tx_sel;
        inc      = run & (src_sel ? cnt_fall : tick);
        ovf_evt  = inc & (&st_q.count);
        trig_evt = trig_en & trig_fall;
        rl_evt   = (ovf_evt & (baud | ~cap_mode)) | (trig_evt & ~baud & ~cap_mode);
        cap_evt  = trig_evt & ~baud & cap_mode;

        st_d = st_q;
        if (rl_evt)   st_d.count = st_q.reload;
        else if (inc) st_d.count = st_q.count + ONE;
        for (int b = 0; b < NB; b++) begin
            if (cnt_wr[b]) st_d.count[b*BYTE_W +: BYTE_W] = wdata;
            if (rl_wr[b])  st_d.reload[b*BYTE_W +: BYTE_W] = wdata;
        end
        if (cap_evt) st_d.reload = st_q.count;
        st_d.rx = ovf_evt & rx_sel;
        st_d.tx = ovf_evt & tx_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.count;
    assign reload   = st_q.reload;
    assign rx_pulse = st_q.rx;
    assign tx_pulse = st_q.tx;

    assert_capture_keeps_counting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && inc && !ovf_evt && cnt_wr == '0) |=> count == $past(count) + ONE);
    assert_capture_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> reload == $past(count));
    assert_reload_on_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !cap_mode && cnt_wr == '0) |=> count == $past(reload));
    assert_trig_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !inc && cnt_wr == '0 && rl_wr == '0) |=>
        (count == $past(count) && reload == $past(reload)));
    assert_baud_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pulse |-> $past(rx_sel));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  byte_t wdata,
    input  logic  ovf_evt,
    input  logic  trig_evt,
    output byte_t ctrl
);
    typedef struct packed {
        byte_t word;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic baud;

    always_comb begin
        baud = st_q.word[B_RXS] | st_q.word[B_TXS];
        st_d = st_q;
        if (wr) st_d.word = wdata;
        if (ovf_evt && !baud) st_d.word[B_OVF] = 1'b1;
        if (trig_evt)         st_d.word[B_EVT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.word;

    assert_no_ovf_flag_in_baud_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && (ctrl[B_RXS] || ctrl[B_TXS])) |=> ctrl[B_OVF] == $past(ctrl[B_OVF]));
    assert_event_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && ctrl[B_EVT]) |=> ctrl[B_EVT]);
    assert_hw_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ctrl[B_RXS] && !ctrl[B_TXS]) |=> ctrl[B_OVF]);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2,
    localparam int NB = CNT_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tick_en,
    input  logic              count_pin,
    input  logic              trigger_pin,
    input  logic              irq_en,
    output logic              irq,
    output logic              rx_clk_pulse,
    output logic              tx_clk_pulse
);
    byte_t            ctrl;
    logic [CNT_W-1:0] count, reload;
    logic             cnt_fall, trig_fall, ovf_evt, trig_evt, ctrl_wr;
    logic [NB-1:0]    cnt_wr, rl_wr;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(cnt_fall));
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .pin(trigger_pin), .fall(trig_fall));

    always_comb begin
        ctrl_wr = reg_wr && (int'(reg_addr) == 0);
        for (int b = 0; b < NB; b++) begin
            cnt_wr[b] = reg_wr && (int'(reg_addr) == 1 + b);
            rl_wr[b]  = reg_wr && (int'(reg_addr) == 1 + NB + b);
        end
    end

    tmr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(reg_wdata),
        .ovf_evt(ovf_evt), .trig_evt(trig_evt), .ctrl(ctrl));

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl[B_RUN]), .src_sel(ctrl[B_SRC]), .cap_mode(ctrl[B_CAP]),
        .rx_sel(ctrl[B_RXS]), .tx_sel(ctrl[B_TXS]), .trig_en(ctrl[B_TEN]),
        .tick(tick_en), .cnt_fall(cnt_fall), .trig_fall(trig_fall),
        .cnt_wr(cnt_wr), .rl_wr(rl_wr), .wdata(reg_wdata),
        .count(count), .reload(reload), .ovf_evt(ovf_evt), .trig_evt(trig_evt),
        .rx_pulse(rx_clk_pulse), .tx_pulse(tx_clk_pulse));

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == 0) reg_rdata = ctrl;
        for (int b = 0; b < NB; b++) begin
            if (int'(reg_addr) == 1 + b)      reg_rdata = count[b*BYTE_W +: BYTE_W];
            if (int'(reg_addr) == 1 + NB + b) reg_rdata = reload[b*BYTE_W +: BYTE_W];
        end
    end

    assign irq = irq_en & (ctrl[B_OVF] | ctrl[B_EVT]);

    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && (ctrl[B_OVF] || ctrl[B_EVT])));
endmodule

// File: tb/cap_reload_timer_tb.sv
`timescale 1ns/1ps
module cap_reload_timer_tb;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       tick_en = 1'b0, count_pin = 1'b1, trigger_pin = 1'b1, irq_en = 1'b0;
    logic       irq, rx_clk_pulse, tx_clk_pulse;

    always #2 clk = ~clk;

    cap_reload_timer u_dut (.*);

    int total = 0, bad = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // bench-side model, from the requirements
    logic [7:0]  m_ctrl;
    logic [15:0] m_cnt, m_rl;
    logic [2:0]  m_cs, m_ts;
    logic        m_rx, m_tx;

    function automatic logic fell(input logic [2:0] s);
        return s[2] & ~s[1];
    endfunction

    function automatic logic [15:0] next_count(input logic [7:0] c, input logic [15:0] cnt,
        input logic [15:0] rl, input logic inc, input logic trig, input logic wr,
        input logic [2:0] a, input logic [7:0] d);
        logic baud = c[5] | c[4];
        logic ovf = inc & (cnt == 16'hFFFF);
        logic [15:0] n;
        if ((ovf & (baud | ~c[0])) | (trig & ~baud & ~c[0])) n = rl;
        else if (inc) n = cnt + 16'd1;
        else n = cnt;
        if (wr && a == 3'd1) n[7:0]  = d;
        if (wr && a == 3'd2) n[15:8] = d;
        return n;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= '0; m_cnt <= '0; m_rl <= '0; m_cs <= '1; m_ts <= '1;
            m_rx <= 1'b0; m_tx <= 1'b0;
        end else begin
            logic baud, inc, ovf, trig;
            logic [15:0] nrl;
            logic [7:0]  nc;
            baud = m_ctrl[5] | m_ctrl[4];
            inc  = m_ctrl[2] & (m_ctrl[1] ? fell(m_cs) : tick_en);
            ovf  = inc & (m_cnt == 16'hFFFF);
            trig = m_ctrl[3] & fell(m_ts);
            nrl = m_rl;
            if (reg_wr && reg_addr == 3'd3) nrl[7:0]  = reg_wdata;
            if (reg_wr && reg_addr == 3'd4) nrl[15:8] = reg_wdata;
            if (trig & ~baud & m_ctrl[0]) nrl = m_cnt;
            nc = (reg_wr && reg_addr == 3'd0) ? reg_wdata : m_ctrl;
            if (ovf & ~baud) nc[7] = 1'b1;
            if (trig) nc[6] = 1'b1;
            m_cnt  <= next_count(m_ctrl, m_cnt, m_rl, inc, trig, reg_wr, reg_addr, reg_wdata);
            m_rl   <= nrl;
            m_ctrl <= nc;
            m_rx   <= ovf & m_ctrl[5];
            m_tx   <= ovf & m_ctrl[4];
            m_cs   <= {m_cs[1:0], count_pin};
            m_ts   <= {m_ts[1:0], trigger_pin};
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
        end
    endtask

    // pending input values applied at the next falling edge
    logic       p_wr = 0, p_tick = 0, p_cp = 1, p_tp = 1, p_ie = 0;
    logic [2:0] p_addr = 0;
    logic [7:0] p_data = 0;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int a = 0; a < 5; a++) begin
                reg_addr = 3'(a);
                #0.1;
                case (a)
                    0: chk("ctrl(R5 R9)", {8'h0, reg_rdata}, {8'h0, m_ctrl});
                    1: chk("cnt_lo(R3)",  {8'h0, reg_rdata}, {8'h0, m_cnt[7:0]});
                    2: chk("cnt_hi(R3)",  {8'h0, reg_rdata}, {8'h0, m_cnt[15:8]});
                    3: chk("rl_lo(R6)",   {8'h0, reg_rdata}, {8'h0, m_rl[7:0]});
                    default: chk("rl_hi(R7)", {8'h0, reg_rdata}, {8'h0, m_rl[15:8]});
                endcase
            end
            chk("irq(R11)", {15'h0, irq}, {15'h0, irq_en & (m_ctrl[7] | m_ctrl[6])});
            chk("rx(R8)", {15'h0, rx_clk_pulse}, {15'h0, m_rx});
            chk("tx(R8)", {15'h0, tx_clk_pulse}, {15'h0, m_tx});
            reg_wr = p_wr; reg_addr = p_addr; reg_wdata = p_data;
            tick_en = p_tick; count_pin = p_cp; trigger_pin = p_tp; irq_en = p_ie;
            p_wr = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        p_wr = 1'b1; p_addr = a; p_data = d;
        step(1);
    endtask

    task automatic pulse_trig(input int n);
        for (int i = 0; i < n; i++) begin
            p_tp = 1'b0; step(3);
            p_tp = 1'b1; step(3);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1";
        #7 rst_n = 1'b1;
        step(3);
        cur_tag = "R2";
        wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'hCD); wr(4, 8'hAB); wr(0, 8'h00); step(2);
        cur_tag = "R3";
        wr(0, 8'h04); p_tick = 1; step(10);
        for (int i = 0; i < 20; i++) begin p_tick = 1'($urandom_range(0, 1)); step(1); end
        wr(0, 8'h00); step(5);
        cur_tag = "R4";
        wr(0, 8'h06);
        for (int i = 0; i < 8; i++) begin p_cp = ~p_cp; step(3); end
        cur_tag = "R5";
        wr(1, 8'hF0); wr(2, 8'hFF); wr(0, 8'h04); p_tick = 1; step(30);
        wr(0, 8'h04); step(3);
        cur_tag = "R6";
        wr(0, 8'h0D); pulse_trig(4);
        cur_tag = "R7";
        wr(3, 8'h10); wr(4, 8'hFF); wr(0, 8'h0C); step(300); pulse_trig(3);
        cur_tag = "R8";
        wr(3, 8'hF8); wr(0, 8'h3C); step(40); pulse_trig(2);
        wr(0, 8'h1C); step(20); wr(0, 8'h2C); step(20);
        cur_tag = "R10";
        wr(0, 8'h01); pulse_trig(3); wr(0, 8'h05); pulse_trig(3);
        cur_tag = "R11";
        wr(0, 8'h0D); pulse_trig(1); p_ie = 1; step(3); p_ie = 0; step(3);
        cur_tag = "R9";
        p_ie = 1; p_tp = 1'b0; step(2); wr(0, 8'h08); p_tp = 1'b1; step(4);

        cur_tag = "random R5 R6 R7 R9";
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 5000; i++) begin
            p_tick = 1'($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 3) == 0) p_cp = ~p_cp;
            if ($urandom_range(0, 4) == 0) p_tp = ~p_tp;
            if ($urandom_range(0, 15) == 0) p_ie = ~p_ie;
            if ($urandom_range(0, 7) == 0) begin
                p_wr = 1'b1;
                p_addr = 3'($urandom_range(0, 4));
                p_data = 8'($urandom);
                if (p_addr == 3'd0) p_data[2] = 1'b1;
                if ((p_addr == 3'd2 || p_addr == 3'd4) && $urandom_range(0, 1) == 1) p_data = 8'hFF;
            end
            step(1);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule